// File: doc/BRIEF.md
# Per-Core Interrupt Interface with Priority Masking and Nesting

This block sits between an interrupt distributor and one processor core. On every cycle the distributor presents its best pending interrupt as a valid flag, an ID and an 8-bit priority, where a lower number means a more urgent interrupt. The interface decides whether that candidate may be signalled. The candidate must get past the group enable, a priority mask and a preemption test against the priority the core is already running at. If it passes, the interface raises one of two registered request lines: the fast line (FIQ) or the normal line (IRQ). A control bit picks which line is used.

Software drives the block through a small register port. The port holds a control register, the priority mask, the binary point and a read-only running-priority view. An acknowledge read returns the ID, and an end-of-interrupt (EOI) write retires it. A priority stack records every acknowledged interrupt, so that nested handlers each restore the running priority they interrupted. Each acknowledge and each retirement is passed to the distributor as a one-cycle pulse carrying the ID.

Top module: `irq_cpu_if`

## Requirements
- R1: A request line can be asserted only while the group enable (control bit 0) is set; with it clear, both lines stay low and an acknowledge read returns 1023.
- R2: With control bit 1 set, a qualifying interrupt drives `fiq_o`; with it clear, it drives `irq_o`; the two lines are never both high.
- R3: An interrupt qualifies only if its priority is numerically lower than the priority mask; with a mask of 0xFF, priority 0xFE is signalled and 0xFF is not.
- R4: With binary point 7, no interrupt is signalled while any acknowledged interrupt is still active.
- R5: With binary point b in 0..6 and an interrupt active, a candidate preempts only if priority bits [7:b+1] are numerically lower than the same bits of the running priority.
- R6: An acknowledge read (offset 3) of a qualifying interrupt returns its ID, pushes its priority so that it becomes the running priority, and gives low request lines on the next cycle. On that edge `ack_o` pulses for one cycle with `ack_id_o` set to the ID. If nothing qualifies, the read returns 1023 and changes no state.
- R7: An EOI write (offset 4) whose ID equals the most recently acknowledged active ID pops it. The running priority (read at offset 5) goes back to its value before that acknowledge, and `eoi_o` pulses with `eoi_id_o`. A write of any other ID has no effect.
- R8: After reset the running priority is 0xFF, the mask is 0x00, the binary point is 0, both control bits are clear, and both request lines are low.
- R9: The request lines and the pulses are registered: they reflect the inputs and the register state of the previous clock cycle.
- R10: While DEPTH interrupts are active, nothing qualifies: no request is raised and an acknowledge read returns 1023.
- R11: Register offsets:
  - 0: control, with bit 0 the enable and bit 1 the FIQ select.
  - 1: mask, in bits [7:0].
  - 2: binary point, in bits [2:0].
  - 3: acknowledge.
  - 4: EOI.
  - 5: running priority.

  Writable registers read back their fields, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_valid | input | 1 | Distributor has a pending candidate |
| hp_id | input | ID_W | Candidate interrupt ID |
| hp_prio | input | 8 | Candidate priority, lower is more urgent |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | ID_W | Write data |
| reg_rdata | output | ID_W | Read data, combinational from the offset |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| ack_o | output | 1 | Acknowledge pulse to the distributor |
| ack_id_o | output | ID_W | ID acknowledged |
| eoi_o | output | 1 | End-of-interrupt pulse to the distributor |
| eoi_id_o | output | ID_W | ID retired |

## Verification
The bench builds the block with DEPTH = 4 and ID_W = 10. The shallow stack makes the full condition of R10 reachable in a few acknowledges, and it also lets random runs hit it often. A 10-bit ID keeps the spurious value 1023 representable, and the random candidate IDs stay below it. Directed sequences then walk the binary-point group boundaries, once with a candidate that just fails to preempt and once with one that just succeeds.

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
  parameter int ID_W  = 10,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hp_valid,
  input  logic [ID_W-1:0] hp_id,
  input  logic [7:0]      hp_prio,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [ID_W-1:0] reg_wdata,
  output logic [ID_W-1:0] reg_rdata,
  output logic            fiq_o,
  output logic            irq_o,
  output logic            ack_o,
  output logic [ID_W-1:0] ack_id_o,
  output logic            eoi_o,
  output logic [ID_W-1:0] eoi_id_o
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ID_W-1:0] SPURIOUS = ID_W'(1023);
  localparam logic [2:0] A_CTRL = 3'd0, A_PMR = 3'd1, A_BPR = 3'd2,
                         A_ACK  = 3'd3, A_EOI = 3'd4, A_RUN = 3'd5;

  logic            grp_en, fiq_sel;
  logic [7:0]      pmr_q;
  logic [2:0]      bp_q;
  logic [SP_W-1:0] sp;
  logic [7:0]      st_prio [DEPTH];
  logic [ID_W-1:0] st_id   [DEPTH];

  logic [IDX_W-1:0] top_idx, push_idx;
  logic [7:0]       running, gmask;
  logic             stack_empty, stack_full, preempt_ok, qualify;
  logic             ack_fire, eoi_hit, req_next;
  logic [ID_W-1:0]  top_id;

  assign stack_empty = (sp == '0);
  assign stack_full  = (sp == SP_W'(DEPTH));
  assign top_idx     = IDX_W'(sp - 1'b1);
  assign push_idx    = IDX_W'(sp);
  assign running     = stack_empty ? 8'hFF : st_prio[top_idx];
  assign top_id      = st_id[top_idx];
  assign gmask       = 8'hFF << ({1'b0, bp_q} + 4'd1);

  assign preempt_ok = stack_empty ||
                      ((bp_q != 3'd7) && ((hp_prio & gmask) < (running & gmask)));
  assign qualify    = hp_valid && grp_en && (hp_prio < pmr_q) && !stack_full && preempt_ok;

  assign ack_fire = reg_rd && (reg_addr == A_ACK) && qualify;
  assign eoi_hit  = reg_wr && (reg_addr == A_EOI) && !stack_empty && (reg_wdata == top_id);
  assign req_next = qualify && !ack_fire;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata = ID_W'({fiq_sel, grp_en});
        A_PMR:   reg_rdata = ID_W'(pmr_q);
        A_BPR:   reg_rdata = ID_W'(bp_q);
        A_ACK:   reg_rdata = qualify ? hp_id : SPURIOUS;
        A_RUN:   reg_rdata = ID_W'(running);
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_en  <= 1'b0;
      fiq_sel <= 1'b0;
      pmr_q   <= 8'h00;
      bp_q    <= 3'd0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  begin grp_en <= reg_wdata[0]; fiq_sel <= reg_wdata[1]; end
        A_PMR:   pmr_q <= reg_wdata[7:0];
        A_BPR:   bp_q  <= reg_wdata[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= '0;
    else if (ack_fire) sp <= sp + 1'b1;
    else if (eoi_hit)  sp <= sp - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ack_fire) begin
      st_prio[push_idx] <= hp_prio;
      st_id[push_idx]   <= hp_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_o    <= 1'b0;
      irq_o    <= 1'b0;
      ack_o    <= 1'b0;
      ack_id_o <= '0;
      eoi_o    <= 1'b0;
      eoi_id_o <= '0;
    end else begin
      fiq_o <= req_next && fiq_sel;
      irq_o <= req_next && !fiq_sel;
      ack_o <= ack_fire;
      eoi_o <= eoi_hit;
      if (ack_fire) ack_id_o <= hp_id;
      if (eoi_hit)  eoi_id_o <= reg_wdata;
    end
  end

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o || irq_o) |-> $past(grp_en)); // R1
  AST_FIQ_FOLLOWS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(fiq_sel)); // R2
  AST_IRQ_FOLLOWS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(fiq_sel)); // R2
  AST_MASK_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o || irq_o) |-> $past(hp_prio < pmr_q)); // R3
  AST_NO_PREEMPT_BP7: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q == 3'd7 && !stack_empty) |=> !(fiq_o || irq_o)); // R4
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (!(fiq_o || irq_o) && ack_o)); // R6
  AST_EOI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> (sp == SP_W'($past(sp) - 1'b1))); // R7
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |=> !(fiq_o || irq_o)); // R10
endmodule

// File: tb/irq_cpu_if_bench.sv
`timescale 1ns/1ps
module irq_cpu_if_bench;
  localparam int ID_W = 10;
  localparam int DEPTH = 4;
  localparam time TCLK = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hp_valid = 1'b0;
  logic [ID_W-1:0] hp_id = '0;
  logic [7:0] hp_prio = 8'hFF;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [ID_W-1:0] reg_wdata = '0;
  logic [ID_W-1:0] reg_rdata, ack_id_o, eoi_id_o;
  logic fiq_o, irq_o, ack_o, eoi_o;

  irq_cpu_if #(.ID_W(ID_W), .DEPTH(DEPTH)) u_irq_cpu_if (
    .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fiq_o(fiq_o), .irq_o(irq_o), .ack_o(ack_o),
    .ack_id_o(ack_id_o), .eoi_o(eoi_o), .eoi_id_o(eoi_id_o));

  always #(TCLK/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_en, m_fiq;
  int m_pmr, m_bp, m_sp;
  int m_prio [DEPTH];
  int m_id [DEPTH];

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int m_run();
    return (m_sp == 0) ? 255 : m_prio[m_sp-1];
  endfunction

  function automatic bit m_qual();
    bit pre;
    if (m_sp == 0) pre = 1;
    else if (m_bp == 7) pre = 0;
    else pre = (int'(hp_prio) >> (m_bp + 1)) < (m_run() >> (m_bp + 1));
    return hp_valid && m_en && (int'(hp_prio) < m_pmr) && (m_sp < DEPTH) && pre;
  endfunction

  task automatic step(input bit rd, input bit wr, input logic [2:0] a, input int d);
    bit q, e_ack, e_eoi, fsel;
    int aid;
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = ID_W'(d);
    #1;
    q = m_qual(); fsel = m_fiq; aid = int'(hp_id);
    e_ack = rd && a == 3'd3 && q;
    e_eoi = wr && a == 3'd4 && m_sp > 0 && d == m_id[m_sp-1];
    if (rd) begin
      case (a)
        3'd0: check("R11 ctrl readback", int'(reg_rdata), {m_fiq, m_en});
        3'd1: check("R11 mask readback", int'(reg_rdata), m_pmr);
        3'd2: check("R11 bp readback", int'(reg_rdata), m_bp);
        3'd3: check("R6 ack read id", int'(reg_rdata), q ? aid : 1023);
        3'd5: check("R7 running prio", int'(reg_rdata), m_run());
        default: check("R11 unused offset", int'(reg_rdata), 0);
      endcase
    end
    if (wr) begin
      case (a)
        3'd0: begin m_en = d[0]; m_fiq = d[1]; end
        3'd1: m_pmr = d & 255;
        3'd2: m_bp = d & 7;
        default: ;
      endcase
    end
    if (e_ack) begin m_prio[m_sp] = int'(hp_prio); m_id[m_sp] = aid; m_sp++; end
    if (e_eoi) m_sp--;
    @(negedge clk);
    check("R2 fiq line (R9 timing)", fiq_o, q && !e_ack && fsel);
    check("R1 irq line (R9 timing)", irq_o, q && !e_ack && !fsel);
    check("R6 ack pulse", ack_o, e_ack);
    if (e_ack) check("R6 ack id out", int'(ack_id_o), aid);
    check("R7 eoi pulse", eoi_o, e_eoi);
    if (e_eoi) check("R7 eoi id out", int'(eoi_id_o), d);
    reg_rd = 0; reg_wr = 0;
  endtask

  task automatic cand(input bit v, input int id, input int p);
    hp_valid = v; hp_id = ID_W'(id); hp_prio = 8'(p);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    m_en = 0; m_fiq = 0; m_pmr = 0; m_bp = 0; m_sp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 fiq low after reset", fiq_o, 0);
    check("R8 irq low after reset", irq_o, 0);
    step(1, 0, 3'd5, 0);
    step(1, 0, 3'd1, 0);
    step(1, 0, 3'd0, 0);
    step(1, 0, 3'd2, 0);
    cand(1, 9, 0);
    step(1, 0, 3'd3, 0);
    check("R8 masked after reset", int'(ack_o), 0);

    step(0, 1, 3'd1, 255);
    step(0, 1, 3'd0, 1);
    cand(1, 9, 255);
    step(0, 0, 3'd0, 0);
    check("R3 prio 0xFF under mask 0xFF", irq_o, 0);
    cand(1, 9, 254);
    step(0, 0, 3'd0, 0);
    check("R3 prio 0xFE under mask 0xFF", irq_o, 1);
    step(0, 1, 3'd0, 3);
    step(0, 0, 3'd0, 0);
    check("R2 fiq selected", fiq_o, 1);
    check("R2 irq idle when fiq selected", irq_o, 0);
    step(0, 1, 3'd0, 2);
    step(0, 0, 3'd0, 0);
    check("R1 enable clear", fiq_o | irq_o, 0);

    step(0, 1, 3'd0, 1);
    step(0, 1, 3'd2, 7);
    cand(1, 5, 8'h40);
    step(1, 0, 3'd3, 0);
    cand(1, 6, 8'h10);
    step(0, 0, 3'd0, 0);
    check("R4 bp7 blocks preemption", irq_o, 0);
    step(0, 1, 3'd2, 3);
    step(0, 0, 3'd0, 0);
    check("R5 bp3 group 1 beats 4", irq_o, 1);
    step(1, 0, 3'd3, 0);
    step(0, 1, 3'd4, 5);
    step(1, 0, 3'd5, 0);
    check("R7 mismatched eoi ignored", int'(reg_rdata), 8'h10);
    step(0, 1, 3'd4, 6);
    step(1, 0, 3'd5, 0);
    step(0, 1, 3'd4, 5);
    step(1, 0, 3'd5, 0);
    cand(1, 7, 8'h48);
    step(1, 0, 3'd3, 0);
    cand(1, 8, 8'h40);
    step(0, 0, 3'd0, 0);
    check("R5 bp3 same group no preempt", irq_o, 0);
    step(0, 1, 3'd2, 2);
    step(0, 0, 3'd0, 0);
    check("R5 bp2 group 8 beats 9", irq_o, 1);
    step(0, 1, 3'd4, 7);

    step(0, 1, 3'd2, 0);
    for (int i = 0; i < DEPTH; i++) begin
      cand(1, i + 1, 8'h80 - 8'h20 * i);
      step(1, 0, 3'd3, 0);
    end
    cand(1, 50, 0);
    step(0, 0, 3'd0, 0);
    check("R10 full stack blocks", irq_o, 0);
    step(1, 0, 3'd3, 0);
    for (int i = DEPTH; i > 0; i--) step(0, 1, 3'd4, i);
    step(1, 0, 3'd5, 0);

    void'($urandom(32'd2024));
    for (int n = 0; n < 1500; n++) begin
      cand(($urandom % 5) != 0, $urandom % 1000, ($urandom % 2) ? ($urandom % 256) : 8'hF0 + ($urandom % 16));
      r = $urandom % 10;
      case (r)
        0: step(0, 1, 3'd0, $urandom % 4 | 1);
        1: step(0, 1, 3'd1, ($urandom % 2) ? 255 : $urandom % 256);
        2: step(0, 1, 3'd2, $urandom % 8);
        3, 4, 5: step(1, 0, 3'd3, 0);
        6, 7: step(0, 1, 3'd4, (m_sp > 0 && ($urandom % 4) != 0) ? m_id[m_sp-1] : $urandom % 1000);
        8: step(1, 0, 3'd5, 0);
        default: step(1, 0, 3'($urandom % 8), 0);
      endcase
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule